// File: doc/BRIEF.md
# Seven-Slot Serial Lane Transmitter

This block turns parallel 7-bit words into bit-serial streams for a display link that runs up to four data lanes beside one clock lane. Each data lane sends one word per word period. The word period is seven slots long, and a slot lasts from one bit-clock enable to the next. The words are captured in parallel at the slot boundary where the phase counter wraps. Each word is shifted out starting with its most significant bit. The clock lane repeats a fixed high/low shape of seven slots: four high and three low, a 57:43 duty. That shape is locked to the word boundaries, so the receiver can find where each word starts.

Upstream logic places the next set of words on `words_i` while `load_req_o` is high. That strobe covers the last slot of each period. The lane count is chosen per word with `wide_i`: four lanes carry 24-bit pixels and three lanes carry 18-bit pixels. The block does not know whether the link is single or dual. The upstream logic sets the rate of `bit_en_i`, so the clock lane runs at the pixel rate for a single link and at half the pixel rate for a dual link.

Top module: `ser7_lane_tx`

## Requirements
- R1: A 7-slot phase counter steps on each clock edge where `bit_en_i` is high and runs 0,1,...,6,0. Every word period is therefore exactly seven enabled edges long.
- R2: `words_i` and `wide_i` are sampled only on the enabled edge taken in slot 6. Their values at every other edge have no effect on any output.
- R3: Lane l sends the word from `words_i[7l+6:7l]`, most significant bit first, one bit per slot. Bit 6 is sent in slot 0 and bit 0 in slot 6.
- R4: After the first capture, `clk_lane_o` in slots 0..6 is 1,1,0,0,0,1,1. Its rising edge falls in slot 5, and the next word starts two slots later. Slot 0 of each word is high.
- R5: `load_req_o` is high for all of slot 6 and low in every other slot. This includes the slots after reset, before any capture has taken place.
- R6: Lanes 0..2 always carry data. Lane 3 carries its word when `wide_i` was 1 at the capture. When `wide_i` was 0 at the capture, lane 3 sends seven zeros for that word period.
- R7: While `rst_ni` is low, and after it rises until the first capture, the phase is 0 and all data lanes and the clock lane are low.
- R8: On a clock edge where `bit_en_i` is low, every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Enable that advances the serializer by one bit slot |
| wide_i | input | 1 | Four lanes when 1, three lanes when 0; sampled at capture |
| words_i | input | 28 | Packed words, one per lane; lane l at bits 7l+6..7l |
| load_req_o | output | 1 | High during the last slot of a period: present the next words |
| data_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Clock lane with the 4-high/3-low shape |

## Verification
The word capture and the last shift of the outgoing word happen on the same enabled edge. On that edge each lane must drop the outgoing least significant bit and put up the new most significant bit. The clock lane must go high for slot 0 on the same edge. The bench keeps words back to back with no gap. Outside the capture edge it scrambles `words_i` and `wide_i`, and it leaves some enables out during the second half of the sweep. A deserializer in the bench locks on to the rising edge of the clock lane and rebuilds every word. Each rebuilt word must match the word presented at its capture.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int unsigned SLOTS = 7;
  localparam int unsigned PH_W  = $clog2(SLOTS);
  // bit SLOTS-1 is slot 0 (the slot carrying the word MSB)
  localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b1100011;
endpackage

// File: rtl/ser7_phase_ctr.sv
module ser7_phase_ctr
  import ser7_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o,
  output logic            wrap_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= (phase_q == PH_W'(SLOTS - 1)) ? '0 : phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == PH_W'(SLOTS - 1));
  assign wrap_o  = last_o & en_i;

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PH_W'(SLOTS)) else $error("phase out of range"); // R1
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q)) else $error("phase moved without enable"); // R8
endmodule

// File: rtl/ser7_lane_shift.sv
module ser7_lane_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic         lane_on_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (en_i) begin
      if (load_i) sh_q <= lane_on_i ? word_i : '0;
      else        sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[W-1];

  AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> bit_o == ($past(word_i[W-1]) & $past(lane_on_i)))
    else $error("first bit after capture is not the MSB"); // R3
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(bit_o)) else $error("lane moved without enable"); // R8
endmodule

// File: rtl/ser7_clk_lane.sv
module ser7_clk_lane
  import ser7_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wrap_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            clk_o
);
  logic            started_q;
  logic [PH_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     started_q <= 1'b0;
    else if (wrap_i) started_q <= 1'b1;
  end

  assign idx   = PH_W'(SLOTS - 1) - phase_i;
  assign clk_o = started_q & CLK_SHAPE[idx];

  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !clk_o) else $error("clock lane active before first word"); // R7
endmodule

// File: rtl/ser7_lane_tx.sv
module ser7_lane_tx
  import ser7_pkg::*;
#(
  parameter int unsigned NUM_LANES    = 4,
  parameter int unsigned NARROW_LANES = 3,
  localparam int unsigned WORDS_W     = NUM_LANES * SLOTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 wide_i,
  input  logic [WORDS_W-1:0]   words_i,
  output logic                 load_req_o,
  output logic [NUM_LANES-1:0] data_o,
  output logic                 clk_lane_o
);
  logic [PH_W-1:0]      phase;
  logic                 last_slot;
  logic                 wrap;
  logic [NUM_LANES-1:0] lane_on;

  ser7_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (bit_en_i),
    .phase_o (phase),
    .last_o  (last_slot),
    .wrap_o  (wrap)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    if (l < NARROW_LANES) begin : g_fixed
      assign lane_on[l] = 1'b1;
    end else begin : g_wide
      assign lane_on[l] = wide_i;
    end

    ser7_lane_shift #(.W(SLOTS)) u_shift (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (bit_en_i),
      .load_i    (last_slot),
      .lane_on_i (lane_on[l]),
      .word_i    (words_i[l*SLOTS +: SLOTS]),
      .bit_o     (data_o[l])
    );
  end

  ser7_clk_lane u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .phase_i (phase),
    .clk_o   (clk_lane_o)
  );

  assign load_req_o = last_slot;

  AST_STROBE_TO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_o && bit_en_i) |=> clk_lane_o && !load_req_o)
    else $error("slot 0 after capture not high"); // R4
  AST_NARROW_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_o && bit_en_i && !wide_i) |=> !data_o[NUM_LANES-1])
    else $error("unused lane not silent"); // R6
endmodule

// File: tb/ser7_lane_tx_test.sv
module ser7_lane_tx_test;
  localparam int NWORDS = 128;
  localparam logic [6:0] SHAPE = 7'b1100011; // bit 6 = slot 0

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [27:0] words_i = '0;
  logic        load_req_o;
  logic [3:0]  data_o;
  logic        clk_lane_o;

  int checks = 0;
  int fails = 0;
  int e = 0;
  int nload = 0;
  int rcv = 0;
  int cd = 0;
  bit last_en = 1'b0;
  bit seen_fall = 1'b0;
  bit done = 1'b0;
  logic prev_clk = 1'b0;
  logic [3:0] prev_data = '0;
  logic [6:0] hist [4];

  always #2 clk_i = ~clk_i;

  ser7_lane_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .wide_i(wide_i),
    .words_i(words_i), .load_req_o(load_req_o), .data_o(data_o), .clk_lane_o(clk_lane_o)
  );

  function automatic logic [6:0] raw_word(int j, int l);
    logic [6:0] b = 7'(j);
    case (l)
      0: return b;
      1: return ~b;
      2: return 7'(j * 5 + 3);
      default: return {b[0], b[6:1]} ^ 7'h2A;
    endcase
  endfunction

  function automatic bit wide_of(int j);
    return (j % 3) != 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (e=%0d)", req, act, exp, e);
    end
  endtask

  task automatic observe();
    logic exp_clk;
    if (last_en) e++;
    chk(load_req_o == ((e % 7) == 6), "R5 R1 load_req", load_req_o, (e % 7) == 6);
    exp_clk = (e >= 7) ? SHAPE[6 - (e % 7)] : 1'b0;
    chk(clk_lane_o == exp_clk, "R4 clk_lane shape", clk_lane_o, exp_clk);
    if (e < 7) chk(data_o == 4'h0, "R7 lanes low before first word", data_o, 0);
    if (!last_en && e > 0) chk(data_o == prev_data, "R8 hold without enable", data_o, prev_data);
    if (last_en) begin
      for (int l = 0; l < 4; l++) hist[l] = {hist[l][5:0], data_o[l]};
      if (cd == 1) begin
        cd = 0;
        if (rcv < NWORDS) begin
          for (int l = 0; l < 4; l++) begin
            logic [6:0] xw;
            xw = (l == 3 && !wide_of(rcv)) ? 7'h0 : raw_word(rcv, l);
            if (l == 3) chk(hist[l] == xw, "R6 R3 lane 3 word", hist[l], xw);
            else        chk(hist[l] == xw, "R2 R3 lane word", hist[l], xw);
          end
        end
        rcv++;
      end
      if (seen_fall && !prev_clk && clk_lane_o) cd = 1;
      if (prev_clk && !clk_lane_o) seen_fall = 1'b1;
      prev_clk = clk_lane_o;
    end
    prev_data = data_o;
  endtask

  initial begin
    for (int l = 0; l < 4; l++) hist[l] = '0;
    repeat (3) @(negedge clk_i);
    chk(data_o == 4'h0 && !clk_lane_o, "R7 reset outputs", {data_o, clk_lane_o}, 0);
    chk(!load_req_o, "R5 reset load_req", load_req_o, 0);
    rst_ni = 1'b1;
    for (int cyc = 0; nload < NWORDS + 2; cyc++) begin
      bit en;
      @(negedge clk_i);
      observe();
      en = !(nload >= NWORDS / 2 && (cyc % 5) == 3);
      if (en && (e % 7) == 6) begin
        for (int l = 0; l < 4; l++) words_i[l*7 +: 7] = raw_word(nload, l);
        wide_i = wide_of(nload);
        nload++;
      end else begin
        words_i = 28'(cyc * 32'h9E3779B1);
        wide_i  = cyc[0];
      end
      bit_en_i = en;
      last_en  = en;
    end
    chk(rcv >= NWORDS, "R1 R3 words received", rcv, NWORDS);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", rcv, NWORDS);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule